// File: doc/BRIEF.md
# Clock Generator Power-Down and Power-Up Sequencer

This block decides when the output clocks of a clock generator may run. At power-up it holds every output low and the PLL off until the active-low VTT power-good input is seen low. In that cycle it captures the frequency-select and current-multiplier straps once. It then counts a programmed settling delay in reference-clock cycles and releases the outputs. Each output restarts only while its source is low, so the first pulse has full width.

The active-low power-down pin is asynchronous. It passes through a two-flop synchroniser and is accepted only when it is seen low at two successive rising edges of the CPU complement clock. The non-CPU outputs then stop low in a fixed order, each on its own next falling edge:
- index 0, the free-running PCI output, stops first;
- index 1, the buffered 66 MHz output, stops second;
- all higher indices stop together, each on its own next falling edge.

The CPU pair is never stopped on an edge. It is parked at once: the true leg is driven high at the double-reference current level and the complement leg is undriven. If either of two configuration bits is set, both legs go to high impedance instead. The PLL shutdown output rises only after the last output has stopped. Releasing the pin powers the PLL back up and runs the settling delay again before the outputs restart.

All clock inputs are sampled by `clk`, the reference clock. Each half period of a source clock must span at least one `clk` cycle.

Top module: `pds_sequencer`

## Requirements
- R1: In reset, and until power-good has been seen low, `out_en` is 0, `pll_off` is 1, all `clk_out` bits are 0, and the CPU pair is parked as set by R7 and R8.
- R2: `vtt_pg_n` driven low reaches the sequencer after two synchroniser flops. The straps are then latched into `straps_q`, and `out_en` rises exactly DELAY_CYC+3 `clk` edges after the input changed.
- R3: `straps_q` never changes after the capture in R2. Later changes on `straps_in` and power-down cycles leave it alone.
- R4: Power-down is entered only when the synchronised pin is low at two consecutive rising edges of `cpu_c_in`. A low pulse that covers fewer rising edges has no effect: `pll_off` stays 0 and `out_en` stays 1.
- R5: After power-down is accepted, `clk_out[0]` stops first, then `clk_out[1]`, then every higher index. Each stops on a falling edge of its own source that comes after the previous stage has finished, so the last high cycles are strictly ordered 0 < 1 < each higher index.
- R6: Every high pulse on any `clk_out[i]` is a full source half period. No output starts or stops in the middle of a pulse.
- R7: Outside the running state, with `cfg_pd_tri`=0 and `cfg_stop_tri`=0, the CPU outputs are `cpu_t_oe`=1, `cpu_t_out`=1, `cpu_c_oe`=0, `cpu_c_out`=0 and `cpu_drv2x`=1.
- R8: Outside the running state, with either `cfg_pd_tri` or `cfg_stop_tri` at 1, the outputs `cpu_t_oe`, `cpu_c_oe`, `cpu_t_out`, `cpu_c_out` and `cpu_drv2x` are all 0.
- R9: `pll_off` rises only after every `clk_out` bit has stopped, and all `clk_out` bits stay 0 while it is high.
- R10: Releasing the pin drops `pll_off` three `clk` edges later and runs the delay again, so `out_en` rises DELAY_CYC+3 edges after the release. While running, the CPU outputs follow `cpu_t_in`/`cpu_c_in` with both enables at 1 and `cpu_drv2x`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock that samples all inputs |
| rst_n | input | 1 | Synchronous active-low reset |
| pd_n_pin | input | 1 | Asynchronous active-low power-down request |
| vtt_pg_n | input | 1 | Active-low power-good, asynchronous |
| cpu_t_in | input | 1 | CPU true clock from the PLL |
| cpu_c_in | input | 1 | CPU complement clock from the PLL, also the qualifying clock |
| clk_in | input | NCLK | Non-CPU source clocks; index 0 is stopped first, index 1 second |
| cfg_pd_tri | input | 1 | Register bit: tri-state the CPU pair in power-down |
| cfg_stop_tri | input | 1 | Register bit: tri-state override for the CPU pair |
| straps_in | input | STRAP_W | Frequency-select and multiplier straps |
| clk_out | output | NCLK | Gated non-CPU clocks |
| cpu_t_out | output | 1 | CPU true output level |
| cpu_c_out | output | 1 | CPU complement output level |
| cpu_t_oe | output | 1 | CPU true output drive enable |
| cpu_c_oe | output | 1 | CPU complement output drive enable |
| cpu_drv2x | output | 1 | CPU true leg held at the double-reference current level |
| pll_off | output | 1 | PLL/VCO shutdown |
| out_en | output | 1 | Outputs released (running state) |
| straps_q | output | STRAP_W | Straps captured at power-up |

## Verification
A table takes power-down through all four settings of the two CPU park bits. Each entry tells driven parking apart from high impedance and checks the stop order, the PLL shutdown and the exact restart latency. The source clocks have different half periods, so a wrong stage order or a stop in the middle of a pulse shows up as a misordered last-high time or as a short pulse. A three-cycle low on the pin covers only one complement rising edge and so separates one-edge qualification from two-edge qualification. Changing the straps after capture and between power-down cycles shows whether they are ever sampled again.

// File: rtl/pds_pkg.sv
// Shared types for the power sequencer: top-level states and stop stages.
package pds_pkg;
    typedef enum logic [2:0] {
        ST_WAIT  = 3'd0,   // waiting for power-good
        ST_DELAY = 3'd1,   // settling delay before release
        ST_RUN   = 3'd2,   // outputs running
        ST_STOP  = 3'd3,   // ordered falling-edge shutdown
        ST_PD    = 3'd4    // powered down, PLL off
    } seq_state_t;

    typedef enum logic [1:0] {
        STG_FIRST  = 2'd0,
        STG_SECOND = 2'd1,
        STG_REST   = 2'd2
    } stop_stage_t;
endpackage

// File: rtl/pds_sync.sv
// Multi-bit level synchroniser. Each bit is an independent slow level;
// no bus coherency is assumed. Reset loads RST_VAL (the inactive level).
module pds_sync #(
    parameter int              W       = 2,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    // Shift the asynchronous inputs through STAGES flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pds_pd_qualify.sv
// Power-down qualifier. Counts consecutive rising edges of the CPU
// complement clock at which the synchronised request is low. Assumes
// cpuc is sampled by clk and each of its half periods covers at least one
// clk cycle.
module pds_pd_qualify #(
    parameter int EDGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_n_s,
    input  logic cpuc,
    output logic pd_req
);
    localparam int QW = $clog2(EDGES + 1);

    logic          cpuc_q;
    logic [QW-1:0] low_cnt;
    logic          c_rise;

    assign c_rise = cpuc & ~cpuc_q;
    assign pd_req = (low_cnt == QW'(EDGES));

    // Remember the last sampled complement level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cpuc_q <= 1'b0;
        else        cpuc_q <= cpuc;
    end

    // Count low samples at consecutive rising edges; a high sample clears.
    always_ff @(posedge clk) begin
        if (!rst_n)
            low_cnt <= '0;
        else if (c_rise) begin
            if (pd_n_s)            low_cnt <= '0;
            else if (!pd_req)      low_cnt <= low_cnt + 1'b1;
        end
    end

    // R4: the request can only appear at a complement rising edge with the pin low.
    a_r4_qualified_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pd_req) |-> ($past(c_rise) && !$past(pd_n_s)));
endmodule

// File: rtl/pds_clk_gate.sv
// Glitch-free gate for one non-CPU clock. It starts only while the source
// is low and stops only on a sampled falling edge of the source, so every
// passed pulse is whole. The source is oversampled by clk.
module pds_clk_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_src,
    input  logic start,     // allowed to run
    input  logic arm,       // stop at the next falling edge
    output logic clk_gated,
    output logic stopped
);
    logic src_q;
    logic on_q;
    logic fall;

    assign fall      = src_q & ~clk_src;
    assign clk_gated = clk_src & on_q;
    assign stopped   = ~on_q;

    // Track the previous source level for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= 1'b0;
        else        src_q <= clk_src;
    end

    // Open while the source is low; close on an armed falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            on_q <= 1'b0;
        else if (!on_q && start && !clk_src)
            on_q <= 1'b1;
        else if (on_q && arm && fall)
            on_q <= 1'b0;
    end

    // R6: the gate changes only while the source is low.
    a_r6_open_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(on_q) |-> !$past(clk_src));
    a_r6_close_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(on_q) |-> !$past(clk_src));
endmodule

// File: rtl/pds_sequencer.sv
// Power-down / power-up sequencer for a clock generator.
// Power-up: wait for power-good low, latch the straps once, count DELAY_CYC
// reference cycles, then release the outputs. Power-down: a qualified
// request stops clk_in[0], then clk_in[1], then the rest, each on its own
// falling edge. The CPU pair is parked at once, and the PLL is switched off
// after the last stop. Assumes NCLK >= 3 and that all inputs are sampled
// by clk.
module pds_sequencer
    import pds_pkg::*;
#(
    parameter int NCLK       = 6,
    parameter int DELAY_CYC  = 3580,
    parameter int QUAL_EDGES = 2,
    parameter int STRAP_W    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pd_n_pin,
    input  logic               vtt_pg_n,
    input  logic               cpu_t_in,
    input  logic               cpu_c_in,
    input  logic [NCLK-1:0]    clk_in,
    input  logic               cfg_pd_tri,
    input  logic               cfg_stop_tri,
    input  logic [STRAP_W-1:0] straps_in,
    output logic [NCLK-1:0]    clk_out,
    output logic               cpu_t_out,
    output logic               cpu_c_out,
    output logic               cpu_t_oe,
    output logic               cpu_c_oe,
    output logic               cpu_drv2x,
    output logic               pll_off,
    output logic               out_en,
    output logic [STRAP_W-1:0] straps_q
);
    localparam int CW = $clog2(DELAY_CYC + 1);

    seq_state_t   state;
    stop_stage_t  stg;
    logic [CW-1:0] cnt;
    logic          pd_n_s, pg_n_s, pd_req;
    logic [NCLK-1:0] stopped;
    logic [NCLK-1:0] arm;
    logic          park_tri;

    pds_sync #(.W(2), .STAGES(2), .RST_VAL(2'b11)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({pd_n_pin, vtt_pg_n}), .q({pd_n_s, pg_n_s})
    );

    pds_pd_qualify #(.EDGES(QUAL_EDGES)) u_qual (
        .clk(clk), .rst_n(rst_n), .pd_n_s(pd_n_s), .cpuc(cpu_c_in), .pd_req(pd_req)
    );

    // One gate per non-CPU clock; the stage that arms it depends on its index.
    for (genvar i = 0; i < NCLK; i++) begin : g_gate
        if (i == 0) begin : g_first
            assign arm[i] = (state == ST_STOP) && (stg == STG_FIRST);
        end else if (i == 1) begin : g_second
            assign arm[i] = (state == ST_STOP) && (stg == STG_SECOND);
        end else begin : g_rest
            assign arm[i] = (state == ST_STOP) && (stg == STG_REST);
        end
        pds_clk_gate u_gate (
            .clk(clk), .rst_n(rst_n), .clk_src(clk_in[i]),
            .start(state == ST_RUN), .arm(arm[i]),
            .clk_gated(clk_out[i]), .stopped(stopped[i])
        );
    end

    // Sequencer state, stop stage, delay counter and strap capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_WAIT;
            stg      <= STG_FIRST;
            cnt      <= '0;
            straps_q <= '0;
        end else begin
            case (state)
                ST_WAIT: if (!pg_n_s) begin
                    straps_q <= straps_in;
                    cnt      <= '0;
                    state    <= ST_DELAY;
                end
                ST_DELAY: begin
                    if (cnt == CW'(DELAY_CYC - 1)) state <= ST_RUN;
                    else                           cnt   <= cnt + 1'b1;
                end
                ST_RUN: if (pd_req && !pd_n_s) begin
                    stg   <= STG_FIRST;
                    state <= ST_STOP;
                end
                ST_STOP: begin
                    case (stg)
                        STG_FIRST:  if (stopped[0]) stg <= STG_SECOND;
                        STG_SECOND: if (stopped[1]) stg <= STG_REST;
                        default:    if (&stopped)   state <= ST_PD;
                    endcase
                end
                ST_PD: if (pd_n_s) begin
                    cnt   <= '0;
                    state <= ST_DELAY;
                end
                default: state <= ST_WAIT;
            endcase
        end
    end

    assign out_en   = (state == ST_RUN);
    assign pll_off  = (state == ST_PD) || (state == ST_WAIT);
    assign park_tri = cfg_pd_tri | cfg_stop_tri;

    // CPU pair: follow the PLL while running, otherwise park or float.
    always_comb begin
        if (state == ST_RUN) begin
            cpu_t_out = cpu_t_in;  cpu_c_out = cpu_c_in;
            cpu_t_oe  = 1'b1;      cpu_c_oe  = 1'b1;
            cpu_drv2x = 1'b0;
        end else if (park_tri) begin
            cpu_t_out = 1'b0;      cpu_c_out = 1'b0;
            cpu_t_oe  = 1'b0;      cpu_c_oe  = 1'b0;
            cpu_drv2x = 1'b0;
        end else begin
            cpu_t_out = 1'b1;      cpu_c_out = 1'b0;
            cpu_t_oe  = 1'b1;      cpu_c_oe  = 1'b0;
            cpu_drv2x = 1'b1;
        end
    end

    // R5: a later stage starts only after the earlier gates have closed.
    a_r5_second_after_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && stg != STG_FIRST) |-> stopped[0]);
    a_r5_rest_after_second: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && stg == STG_REST) |-> (stopped[1] && stopped[0]));
    // R9: with the PLL off after a power-down, every gated clock is quiet.
    a_r9_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PD) |-> (clk_out == '0 && pll_off));
    // R3: the straps are frozen once capture has happened.
    a_r3_straps_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_WAIT) |=> $stable(straps_q));
    // R10: a released pin in power-down turns the PLL back on next cycle.
    a_r10_pll_back_on: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PD && pd_n_s) |=> !pll_off);
    // R8: the CPU pair never drives outside the running state when tri-stating is selected.
    a_r8_cpu_float: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_en && park_tri) |-> !(cpu_t_oe || cpu_c_oe));
endmodule

// File: tb/pds_sequencer_bench.sv
module pds_sequencer_bench;
    localparam int NCLK  = 6;
    localparam int DELAY = 64;
    localparam int SW    = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pd_n_pin = 1'b1, vtt_pg_n = 1'b1;
    logic cpu_t_in = 1'b1, cpu_c_in = 1'b0;
    logic [NCLK-1:0] clk_in = '0;
    logic cfg_pd_tri = 1'b0, cfg_stop_tri = 1'b0;
    logic [SW-1:0] straps_in = 4'hA;
    logic [NCLK-1:0] clk_out;
    logic cpu_t_out, cpu_c_out, cpu_t_oe, cpu_c_oe, cpu_drv2x, pll_off, out_en;
    logic [SW-1:0] straps_q;

    int n_tests = 0, n_fail = 0, cyc = 0, bad_pulses = 0, good_pulses = 0;
    int hl_len [NCLK];
    int last_hi [NCLK];
    bit done = 1'b0;

    always #5 clk = ~clk;

    pds_sequencer #(.NCLK(NCLK), .DELAY_CYC(DELAY), .QUAL_EDGES(2), .STRAP_W(SW)) u_pds_sequencer (
        .clk(clk), .rst_n(rst_n), .pd_n_pin(pd_n_pin), .vtt_pg_n(vtt_pg_n),
        .cpu_t_in(cpu_t_in), .cpu_c_in(cpu_c_in), .clk_in(clk_in),
        .cfg_pd_tri(cfg_pd_tri), .cfg_stop_tri(cfg_stop_tri), .straps_in(straps_in),
        .clk_out(clk_out), .cpu_t_out(cpu_t_out), .cpu_c_out(cpu_c_out),
        .cpu_t_oe(cpu_t_oe), .cpu_c_oe(cpu_c_oe), .cpu_drv2x(cpu_drv2x),
        .pll_off(pll_off), .out_en(out_en), .straps_q(straps_q)
    );

    // Source clocks: clk_in[i] half period 3+i cycles, CPU pair half period 2.
    initial begin
        int ph [NCLK];
        int cph;
        cph = 0;
        for (int i = 0; i < NCLK; i++) ph[i] = 0;
        forever begin
            @(posedge clk); #1;
            for (int i = 0; i < NCLK; i++) begin
                ph[i]++;
                if (ph[i] == 3 + i) begin ph[i] = 0; clk_in[i] = ~clk_in[i]; end
            end
            cph++;
            if (cph == 2) begin cph = 0; cpu_c_in = ~cpu_c_in; cpu_t_in = ~cpu_c_in; end
        end
    end

    // Pulse-width and last-high monitor on the gated outputs (R6, R5).
    initial begin
        for (int i = 0; i < NCLK; i++) begin hl_len[i] = 0; last_hi[i] = 0; end
        forever begin
            @(negedge clk);
            cyc++;
            for (int i = 0; i < NCLK; i++) begin
                if (clk_out[i]) begin
                    hl_len[i]++;
                    last_hi[i] = cyc;
                end else if (hl_len[i] != 0) begin
                    if (hl_len[i] != 3 + i) begin
                        bad_pulses++;
                        $display("FAIL R6 clk_out[%0d] pulse actual=%0d expected=%0d", i, hl_len[i], 3 + i);
                    end else good_pulses++;
                    hl_len[i] = 0;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL R10 watchdog actual=timeout expected=finished");
        summary();
    end

    // {pd_tri, stop_tri, exp t_oe, exp c_oe, exp t_out, exp drv2x}
    localparam logic [5:0] VEC [4] = '{
        6'b00_1011,
        6'b01_0000,
        6'b10_0000,
        6'b11_0000
    };

    initial begin
        // R1: reset and pre-power-good state.
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R1 out_en in reset", 32'(out_en), 32'd0);
        chk("R1 pll_off in reset", 32'(pll_off), 32'd1);
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (20) @(posedge clk);
        @(negedge clk);
        chk("R1 clk_out before power-good", 32'(clk_out), 32'd0);
        chk("R1 pll_off before power-good", 32'(pll_off), 32'd1);
        chk("R1 cpu park before power-good", {cpu_t_oe, cpu_c_oe, cpu_t_out, cpu_drv2x}, 4'b1011);

        // R2: exact release latency after power-good.
        @(posedge clk); #1 vtt_pg_n = 1'b0;
        repeat (DELAY + 2) @(posedge clk);
        @(negedge clk);
        chk("R2 out_en one edge early", 32'(out_en), 32'd0);
        @(posedge clk); @(negedge clk);
        chk("R2 out_en at release", 32'(out_en), 32'd1);
        chk("R2 straps latched", 32'(straps_q), 32'hA);
        straps_in = 4'h5;
        repeat (100) @(posedge clk);

        // Table of park settings through full power-down and restart.
        for (int v = 0; v < 4; v++) begin
            bit ord_ok;
            @(posedge clk); #1;
            cfg_pd_tri   = VEC[v][5];
            cfg_stop_tri = VEC[v][4];
            pd_n_pin     = 1'b0;
            repeat (200) @(posedge clk);
            @(negedge clk);
            chk(v == 0 ? "R7 cpu park driven" : "R8 cpu park floating",
                {cpu_t_oe, cpu_c_oe, cpu_t_out, cpu_drv2x}, 32'(VEC[v][3:0]));
            chk(v == 0 ? "R7 cpu_c_out low" : "R8 cpu_c_out low", 32'(cpu_c_out), 32'd0);
            chk("R9 pll_off in power-down", 32'(pll_off), 32'd1);
            chk("R9 clk_out held low", 32'(clk_out), 32'd0);
            chk("R4 out_en dropped", 32'(out_en), 32'd0);
            ord_ok = (last_hi[0] < last_hi[1]);
            for (int k = 2; k < NCLK; k++) if (last_hi[k] <= last_hi[1]) ord_ok = 1'b0;
            chk("R5 stop order", 32'(ord_ok), 32'd1);

            // R10: release and exact restart latency.
            @(posedge clk); #1 pd_n_pin = 1'b1;
            repeat (2) @(posedge clk); @(negedge clk);
            chk("R10 pll still off before sync", 32'(pll_off), 32'd1);
            @(posedge clk); @(negedge clk);
            chk("R10 pll on after release", 32'(pll_off), 32'd0);
            chk("R10 delay re-run", 32'(out_en), 32'd0);
            repeat (DELAY - 1) @(posedge clk); @(negedge clk);
            chk("R10 out_en one edge early", 32'(out_en), 32'd0);
            @(posedge clk); @(negedge clk);
            chk("R10 out_en restored", 32'(out_en), 32'd1);
            repeat (40) @(posedge clk); @(negedge clk);
            chk("R10 cpu running enables", {cpu_t_oe, cpu_c_oe, cpu_drv2x}, 3'b110);
            chk("R10 cpu follows input", {cpu_t_out, cpu_c_out}, {cpu_t_in, cpu_c_in});
            chk("R3 straps unchanged", 32'(straps_q), 32'hA);
        end

        // R4: a short low pulse covers one complement edge only.
        cfg_pd_tri = 1'b0; cfg_stop_tri = 1'b0;
        @(posedge clk); #1 pd_n_pin = 1'b0;
        repeat (3) @(posedge clk); #1 pd_n_pin = 1'b1;
        repeat (40) @(posedge clk); @(negedge clk);
        chk("R4 short pulse pll_off", 32'(pll_off), 32'd0);
        chk("R4 short pulse out_en", 32'(out_en), 32'd1);

        // R3: strap change after capture is ignored.
        straps_in = 4'h3;
        repeat (20) @(posedge clk); @(negedge clk);
        chk("R3 straps ignore later change", 32'(straps_q), 32'hA);

        // R6: every gated pulse was whole.
        chk("R6 short pulses", 32'(bad_pulses), 32'd0);
        chk("R6 pulses observed", 32'(good_pulses > 50), 32'd1);
        summary();
    end
endmodule